// File: doc/BRIEF.md
# DRAM Command Issue-Cycle Timer

This block tells a DRAM command scheduler the earliest clock cycle at which a candidate command may be issued to a given bank. The scheduler presents a command code, a bank index and the cycle it would like to use. The block combines that cycle with two histories: what was last issued to the target bank, and which column command (read or write) was last issued anywhere on the device. It then returns the latest of the requested cycle and every timing window still open. All timing values are static cycle counts supplied on configuration inputs.

When the scheduler commits the command, it pulses `accept` in the same cycle. The block then records the command and the returned issue cycle, and later requests are measured against that record. A precharge-all is checked against every bank and recorded in all of them. The bank group is taken from the upper bits of the bank index. It decides whether the long or the short column-to-column and write-to-read spacings apply.

Top module: `dram_cmd_timer`

## Requirements
- R1: After reset no bank and no device column history exists, so `issue_cycle` equals `req_cycle` for any command.
- R2: `issue_cycle` is the maximum of `req_cycle` and every open constraint, so it is never earlier than requested and equals `req_cycle` when no window is open.
- R3: Burst length in cycles is `cfg_bl/2` when `cfg_ddr`=1 and `cfg_bl` when `cfg_ddr`=0. The same value enters every read and write term.
- R4: An ACT or REF on a bank waits `t_rtp+t_rp` after an RDA on that bank, and `t_rp` after a PRE or PREA on it.
- R5: An ACT, REF or PRE on a bank waits `t_wl+burst+t_wr+t_rp` after a WRA on that bank.
- R6: A PRE waits `t_wl+burst+t_wr` after a WR and `t_rtp` after an RD on the same bank. Any ACT, REF, PRE, PREA or column command waits `t_xp` after a power-down exit (PDXA or PDXP) on that bank.
- R7: A read after a read, or a write after a write, is spaced `max(tccd, burst)` from the previous column command on any bank. `tccd` is `t_ccd_l` when both banks share a group (group = bank index divided by NBANK/NGROUP) and `t_ccd_s` otherwise.
- R8: A read after a write is spaced `t_wl+burst+t_wtr_l` within a group and `t_wl+burst+t_wtr_s` across groups.
- R9: A write after a read is spaced `t_rl+burst+2-t_wl`, floored at zero.
- R10: An ACT or REF after a REF on the same bank waits `t_rfc1`, `t_rfc2` or `t_rfc4` for `ref_mode` 1, 2 or 4. Any other mode value uses `t_rfc1`.
- R11: A PREA takes the latest precharge constraint over all banks. When accepted, it records PREA at its issue cycle in every bank.
- R12: History changes only on `accept`, storing the command and `issue_cycle` for the target bank. Command codes are 1 ACT, 2 PRE, 3 PREA, 4 RD, 5 RDA, 6 WR, 7 WRA, 8 REF, 9 PDXA, 10 PDXP. Any other code imposes no constraint and leaves the history unchanged when accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_rp | input | TW | Precharge period |
| t_rtp | input | TW | Read to precharge |
| t_wl | input | TW | Write latency |
| t_rl | input | TW | Read latency |
| t_wr | input | TW | Write recovery |
| t_wtr_l | input | TW | Write to read, same group |
| t_wtr_s | input | TW | Write to read, other group |
| t_ccd_l | input | TW | Column spacing, same group |
| t_ccd_s | input | TW | Column spacing, other group |
| t_xp | input | TW | Power-down exit to next command |
| t_rfc1 | input | TW | Refresh period, mode 1 |
| t_rfc2 | input | TW | Refresh period, mode 2 |
| t_rfc4 | input | TW | Refresh period, mode 4 |
| cfg_bl | input | TW | Burst length in beats |
| cfg_ddr | input | 1 | 1: two beats per clock |
| ref_mode | input | 3 | Refresh granularity (1, 2, 4) |
| req_cmd | input | 4 | Candidate command code |
| req_bank | input | log2(NBANK) | Target bank |
| req_cycle | input | CW | Requested issue cycle |
| accept | input | 1 | Commit the candidate at `issue_cycle` |
| issue_cycle | output | CW | Earliest legal issue cycle |

## Verification
The bench builds the block with its defaults: eight banks in two groups, 16-bit cycle counts and 8-bit timing fields. This gives each pair of banks on the bench's path either a shared group or a split one, so both the long and the short spacing are reached. The timing values are chosen so that `t_ccd_s` ties the double-rate burst and `t_ccd_l` exceeds it. Switching `cfg_ddr` off then lets the burst exceed `t_ccd_l`. The refresh periods differ per mode, so each of the three selections and the fallback produce a distinct issue cycle.

// File: rtl/dram_cmd_timer.sv
module dram_cmd_timer #(
  parameter int NBANK  = 8,
  parameter int NGROUP = 2,
  parameter int CW     = 16,
  parameter int TW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TW-1:0]            t_rp,
  input  logic [TW-1:0]            t_rtp,
  input  logic [TW-1:0]            t_wl,
  input  logic [TW-1:0]            t_rl,
  input  logic [TW-1:0]            t_wr,
  input  logic [TW-1:0]            t_wtr_l,
  input  logic [TW-1:0]            t_wtr_s,
  input  logic [TW-1:0]            t_ccd_l,
  input  logic [TW-1:0]            t_ccd_s,
  input  logic [TW-1:0]            t_xp,
  input  logic [TW-1:0]            t_rfc1,
  input  logic [TW-1:0]            t_rfc2,
  input  logic [TW-1:0]            t_rfc4,
  input  logic [TW-1:0]            cfg_bl,
  input  logic                     cfg_ddr,
  input  logic [2:0]               ref_mode,
  input  logic [3:0]               req_cmd,
  input  logic [$clog2(NBANK)-1:0] req_bank,
  input  logic [CW-1:0]            req_cycle,
  input  logic                     accept,
  output logic [CW-1:0]            issue_cycle
);
  localparam int BW  = $clog2(NBANK);
  localparam int GSH = $clog2(NBANK / NGROUP);

  localparam logic [3:0] K_ACT  = 4'd1;
  localparam logic [3:0] K_PRE  = 4'd2;
  localparam logic [3:0] K_PREA = 4'd3;
  localparam logic [3:0] K_RD   = 4'd4;
  localparam logic [3:0] K_RDA  = 4'd5;
  localparam logic [3:0] K_WR   = 4'd6;
  localparam logic [3:0] K_WRA  = 4'd7;
  localparam logic [3:0] K_REF  = 4'd8;
  localparam logic [3:0] K_PDXA = 4'd9;
  localparam logic [3:0] K_PDXP = 4'd10;

  localparam logic [1:0] L_NONE = 2'd0;
  localparam logic [1:0] L_RD   = 2'd1;
  localparam logic [1:0] L_WR   = 2'd2;

  // R3: burst cycles from burst length and beats per clock
  wire [CW-1:0] burst = cfg_ddr ? CW'(cfg_bl >> 1) : CW'(cfg_bl);

  // R10: refresh period chosen by granularity
  logic [CW-1:0] rfc;
  always_comb
    case (ref_mode)
      3'd2:    rfc = CW'(t_rfc2);
      3'd4:    rfc = CW'(t_rfc4);
      default: rfc = CW'(t_rfc1);
    endcase

  wire [CW-1:0] d_rp   = CW'(t_rp);
  wire [CW-1:0] d_rtp  = CW'(t_rtp);
  wire [CW-1:0] d_xp   = CW'(t_xp);
  wire [CW-1:0] d_rdap = d_rtp + d_rp;
  wire [CW-1:0] d_wrec = CW'(t_wl) + burst + CW'(t_wr);
  wire [CW-1:0] d_wrap = d_wrec + d_rp;

  wire is_row = (req_cmd == K_ACT) || (req_cmd == K_REF);
  wire is_rd  = (req_cmd == K_RD)  || (req_cmd == K_RDA);
  wire is_wr  = (req_cmd == K_WR)  || (req_cmd == K_WRA);
  wire known  = (req_cmd >= K_ACT) && (req_cmd <= K_PDXP);

  logic [3:0]    h_cmd [NBANK];
  logic [CW-1:0] h_cyc [NBANK];
  logic [CW-1:0] e_row [NBANK];
  logic [CW-1:0] e_pre [NBANK];
  logic [CW-1:0] e_cas [NBANK];

  // Per-bank window ends, zero when the history opens no window
  always_comb
    for (int b = 0; b < NBANK; b++) begin
      e_row[b] = '0;
      e_pre[b] = '0;
      e_cas[b] = '0;
      case (h_cmd[b])
        K_PRE, K_PREA: e_row[b] = h_cyc[b] + d_rp;
        K_REF:         e_row[b] = h_cyc[b] + rfc;
        K_RD:          e_pre[b] = h_cyc[b] + d_rtp;
        K_WR:          e_pre[b] = h_cyc[b] + d_wrec;
        K_RDA: begin
          e_row[b] = h_cyc[b] + d_rdap;
          e_pre[b] = h_cyc[b] + d_rdap;
        end
        K_WRA: begin
          e_row[b] = h_cyc[b] + d_wrap;
          e_pre[b] = h_cyc[b] + d_wrap;
        end
        K_PDXA, K_PDXP: begin
          e_row[b] = h_cyc[b] + d_xp;
          e_pre[b] = h_cyc[b] + d_xp;
          e_cas[b] = h_cyc[b] + d_xp;
        end
        default: ;
      endcase
    end

  logic [CW-1:0] b_lim;
  always_comb begin
    b_lim = '0;
    if (is_row)                  b_lim = e_row[req_bank];
    else if (req_cmd == K_PRE)   b_lim = e_pre[req_bank];
    else if (is_rd || is_wr)     b_lim = e_cas[req_bank];
    else if (req_cmd == K_PREA)
      for (int b = 0; b < NBANK; b++)
        if (e_pre[b] > b_lim) b_lim = e_pre[b];
  end

  // Device-wide column history
  logic [1:0]    l_kind;
  logic [CW-1:0] l_cyc;
  logic [BW-1:0] l_bank;

  wire           same_grp = (req_bank >> GSH) == (l_bank >> GSH);
  wire [CW-1:0]  ccd      = same_grp ? CW'(t_ccd_l) : CW'(t_ccd_s);
  wire [CW-1:0]  ccd_eff  = (ccd > burst) ? ccd : burst;
  wire [CW-1:0]  wtr      = same_grp ? CW'(t_wtr_l) : CW'(t_wtr_s);
  wire [CW-1:0]  w2r      = CW'(t_wl) + burst + wtr;
  wire [CW-1:0]  rd_span  = CW'(t_rl) + burst + CW'(2);
  wire [CW-1:0]  r2w      = (rd_span > CW'(t_wl)) ? rd_span - CW'(t_wl) : '0;

  logic [CW-1:0] d_lim;
  always_comb begin
    d_lim = '0;
    if (is_rd)
      case (l_kind)
        L_RD:    d_lim = l_cyc + ccd_eff;
        L_WR:    d_lim = l_cyc + w2r;
        default: ;
      endcase
    else if (is_wr)
      case (l_kind)
        L_WR:    d_lim = l_cyc + ccd_eff;
        L_RD:    d_lim = l_cyc + r2w;
        default: ;
      endcase
  end

  // R2: latest of request and both limits
  wire [CW-1:0] m1 = (req_cycle > b_lim) ? req_cycle : b_lim;
  assign issue_cycle = (m1 > d_lim) ? m1 : d_lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        h_cmd[b] <= '0;
        h_cyc[b] <= '0;
      end
      l_kind <= L_NONE;
      l_cyc  <= '0;
      l_bank <= '0;
    end else if (accept && known) begin
      for (int b = 0; b < NBANK; b++)
        if (req_cmd == K_PREA || BW'(b) == req_bank) begin
          h_cmd[b] <= req_cmd;
          h_cyc[b] <= issue_cycle;
        end
      if (is_rd || is_wr) begin
        l_kind <= is_rd ? L_RD : L_WR;
        l_cyc  <= issue_cycle;
        l_bank <= req_bank;
      end
    end
endmodule

// File: rtl/dram_cmd_timer_chk.sv
module dram_cmd_timer_chk #(
  parameter int BW = 3,
  parameter int CW = 16,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] t_rp,
  input logic [TW-1:0] t_wl,
  input logic [TW-1:0] t_wr,
  input logic [TW-1:0] t_ccd_l,
  input logic [TW-1:0] t_ccd_s,
  input logic [TW-1:0] t_rfc4,
  input logic          cfg_ddr,
  input logic [2:0]    ref_mode,
  input logic [3:0]    req_cmd,
  input logic [BW-1:0] req_bank,
  input logic [CW-1:0] req_cycle,
  input logic          accept,
  input logic [CW-1:0] issue_cycle
);
  localparam int XW = CW + 2;
  wire [TW-1:0] ccd_min = (t_ccd_l < t_ccd_s) ? t_ccd_l : t_ccd_s;

  assert_not_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cycle >= req_cycle);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(accept) && $stable(req_cmd) && $stable(req_bank) && $stable(req_cycle)
     && $stable(ref_mode) && $stable(cfg_ddr)) |-> $stable(issue_cycle));

  assert_pre_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && req_cmd == 4'd2) && req_cmd == 4'd1 && req_bank == $past(req_bank))
    |-> XW'(issue_cycle) >= XW'($past(issue_cycle)) + XW'(t_rp));

  assert_wra_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && req_cmd == 4'd7) && req_cmd == 4'd1 && req_bank == $past(req_bank))
    |-> XW'(issue_cycle) >= XW'($past(issue_cycle)) + XW'(t_wl) + XW'(t_wr) + XW'(t_rp));

  assert_rd_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && req_cmd == 4'd4) && req_cmd == 4'd4)
    |-> XW'(issue_cycle) >= XW'($past(issue_cycle)) + XW'(ccd_min));

  assert_rfc4_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && req_cmd == 4'd8) && req_cmd == 4'd1 && req_bank == $past(req_bank)
     && ref_mode == 3'd4)
    |-> XW'(issue_cycle) >= XW'($past(issue_cycle)) + XW'(t_rfc4));
endmodule

bind dram_cmd_timer dram_cmd_timer_chk #(.BW($clog2(NBANK)), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .t_rp(t_rp), .t_wl(t_wl), .t_wr(t_wr),
  .t_ccd_l(t_ccd_l), .t_ccd_s(t_ccd_s), .t_rfc4(t_rfc4), .cfg_ddr(cfg_ddr),
  .ref_mode(ref_mode), .req_cmd(req_cmd), .req_bank(req_bank),
  .req_cycle(req_cycle), .accept(accept), .issue_cycle(issue_cycle)
);

// File: tb/dram_cmd_timer_test.sv
`timescale 1ns/1ps
module dram_cmd_timer_test;
  localparam int CW = 16, TW = 8, NBANK = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [TW-1:0] t_rp, t_rtp, t_wl, t_rl, t_wr, t_wtr_l, t_wtr_s, t_ccd_l, t_ccd_s;
  logic [TW-1:0] t_xp, t_rfc1, t_rfc2, t_rfc4, cfg_bl;
  logic cfg_ddr;
  logic [2:0] ref_mode;
  logic [3:0] req_cmd;
  logic [2:0] req_bank;
  logic [CW-1:0] req_cycle;
  logic accept;
  logic [CW-1:0] issue_cycle;

  dram_cmd_timer #(.NBANK(NBANK), .NGROUP(2), .CW(CW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .t_rp(t_rp), .t_rtp(t_rtp), .t_wl(t_wl), .t_rl(t_rl),
    .t_wr(t_wr), .t_wtr_l(t_wtr_l), .t_wtr_s(t_wtr_s), .t_ccd_l(t_ccd_l),
    .t_ccd_s(t_ccd_s), .t_xp(t_xp), .t_rfc1(t_rfc1), .t_rfc2(t_rfc2),
    .t_rfc4(t_rfc4), .cfg_bl(cfg_bl), .cfg_ddr(cfg_ddr), .ref_mode(ref_mode),
    .req_cmd(req_cmd), .req_bank(req_bank), .req_cycle(req_cycle),
    .accept(accept), .issue_cycle(issue_cycle)
  );

  typedef struct packed {
    logic        acc;
    logic [2:0]  mode;
    logic [3:0]  cmd;
    logic [2:0]  bank;
    logic [15:0] req;
    logic [15:0] exp;
    logic [7:0]  tag;
  } vec_t;

  function automatic vec_t mk(input logic a, input int m, input int c, input int b,
                              input int r, input int e, input int t);
    mk = '{acc: a, mode: 3'(m), cmd: 4'(c), bank: 3'(b), req: 16'(r), exp: 16'(e), tag: 8'(t)};
  endfunction

  // burst 4, rdap 7, wrec 15, wrap 19, ccd same 6 / other 4,
  // wr->rd same 13 / other 11, rd->wr 8, rfc 20/14/9
  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    mk(1,1, 1,0, 10, 10, 1),   // R1 empty history
    mk(1,1, 4,0, 12, 12, 2),   // R2
    mk(1,1, 4,1, 13, 18, 7),   // R7 same group
    mk(1,1, 4,4, 19, 22, 7),   // R7 other group
    mk(1,1, 6,5, 23, 30, 9),   // R9
    mk(1,1, 4,6, 31, 43, 8),   // R8 same group
    mk(1,1, 6,2, 44, 51, 9),   // R9
    mk(1,1, 4,4, 52, 62, 8),   // R8 other group
    mk(1,1, 2,2, 55, 66, 6),   // R6 PRE after WR
    mk(1,1, 1,2, 67, 70, 4),   // R4 ACT after PRE
    mk(1,1, 2,4, 60, 65, 6),   // R6 PRE after RD
    mk(0,1, 1,4,100,100, 2),   // R2 request later than window
    mk(1,1, 1,4, 66, 69, 4),   // R4
    mk(1,1, 7,4, 70, 70, 9),   // R9 exact
    mk(1,1, 1,4, 71, 89, 5),   // R5 ACT after WRA
    mk(1,1, 5,3, 90, 90, 2),   // R2
    mk(1,1, 1,3, 91, 97, 4),   // R4 ACT after RDA
    mk(1,1, 8,7, 98, 98, 2),   // R2
    mk(1,1, 1,7, 99,118,10),   // R10 mode 1
    mk(1,1, 8,7,120,120, 2),   // R2
    mk(0,2, 1,7,121,134,10),   // R10 mode 2
    mk(0,4, 1,7,121,129,10),   // R10 mode 4
    mk(1,3, 1,7,121,140,10),   // R10 other mode
    mk(1,1, 9,5,141,141, 6),   // R6
    mk(1,1, 2,5,142,144, 6),   // R6 PRE after PDXA
    mk(1,1,10,6,150,150, 6),   // R6
    mk(1,1, 4,6,151,153, 6),   // R6 RD after PDXP
    mk(1,1, 3,0,154,156,11),   // R11 PREA max over banks
    mk(0,1, 1,1,157,160,11),   // R11 recorded in bank 1
    mk(1,1,12,1,  5,  5,12),   // R12 unknown code
    mk(0,1, 1,1,157,160,12)    // R12 history untouched
  };

  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic check(input int tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL R%0d: issue_cycle actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic [3:0] c, input logic [2:0] b,
                       input logic [CW-1:0] r);
    @(negedge clk);
    accept = a; req_cmd = c; req_bank = b; req_cycle = r;
    #1;
  endtask

  initial begin
    t_rp = 4; t_rtp = 3; t_wl = 5; t_rl = 7; t_wr = 6; t_wtr_l = 4; t_wtr_s = 2;
    t_ccd_l = 6; t_ccd_s = 4; t_xp = 3; t_rfc1 = 20; t_rfc2 = 14; t_rfc4 = 9;
    cfg_bl = 8; cfg_ddr = 1; ref_mode = 1;
    accept = 0; req_cmd = 0; req_bank = 0; req_cycle = 0;
    rst_n = 0;
    drive(0, 4'd1, 3'd0, 16'd7);
    check(1, issue_cycle, 16'd7);            // R1 during reset
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ref_mode = VEC[i].mode;
      accept = VEC[i].acc; req_cmd = VEC[i].cmd;
      req_bank = VEC[i].bank; req_cycle = VEC[i].req;
      #1;
      check(VEC[i].tag, issue_cycle, VEC[i].exp);
    end

    // R1: reset clears bank and device history
    @(negedge clk) begin accept = 0; rst_n = 0; ref_mode = 1; end
    @(negedge clk) rst_n = 1;
    drive(0, 4'd1, 3'd1, 16'd157);
    check(1, issue_cycle, 16'd157);
    drive(0, 4'd4, 3'd6, 16'd151);
    check(1, issue_cycle, 16'd151);

    // R3: single-rate burst of 8 beats
    cfg_ddr = 0;
    drive(1, 4'd4, 3'd0, 16'd200);
    check(3, issue_cycle, 16'd200);
    drive(1, 4'd4, 3'd1, 16'd201);
    check(3, issue_cycle, 16'd208);
    drive(1, 4'd6, 3'd2, 16'd209);
    check(3, issue_cycle, 16'd220);
    drive(0, 4'd2, 3'd2, 16'd221);
    check(3, issue_cycle, 16'd239);

    @(negedge clk) accept = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule